// File: doc/BRIEF.md
# Masked Cluster-ID and Channel Event Qualifier

This block sits in front of an uncore event counter and decides, one event strobe at a time, whether that event should be counted. Each event arrives with an 11-bit source cluster ID, an 11-bit target cluster ID, a 2-bit channel tag and an 8-bit event code. The upper six bits of an ID name the die and the lower five name the cluster within it. I/O cluster numbers include 5'b00000 for management, 5'b00001 for networking, 5'b00011 for the accelerator cluster and 5'b10000 for PCIe.

Two ID filters, one for source and one for target, each hold a compare value, a don't-care mask and an enable. A third setting picks which transmit channel is counted. That channel choice only applies to a fixed band of event codes. The output is one registered pulse per qualified event. It appears one clock after the strobe and drives the counter's increment input. The filters are set through a small word-wide write port.

Top module: `event_qualifier`

## Requirements
- R1: Reset (synchronous, active high) clears `qual_pulse` and returns the block to its defaults: both ID filters are disabled with compare and mask at zero, and the channel selector is 2'b00. With these defaults every valid event is counted.
- R2: `qual_pulse` is high in the cycle after an edge that sampled `ev_valid` high with all filters passing. It is low in every cycle whose previous edge sampled `ev_valid` low.
- R3: When the source filter is enabled, an event passes it only if `((ev_src ^ cmd) & ~mask) == 0`. A set mask bit therefore excludes that bit position from the comparison.
- R4: The target filter follows the same rule on `ev_tgt`, using its own compare value, mask and enable.
- R5: A disabled ID filter passes every event, whatever its compare value and mask hold.
- R6: Channel selector 2'b00 counts events on either channel.
- R7: Channel selector 2'b01 and selector 2'b11 both count only events tagged as sent on the extended channel (`ev_ch[0]` set).
- R8: Channel selector 2'b10 counts only events tagged as sent on the normal channel (`ev_ch[1]` set).
- R9: The channel selector applies only to event codes 8'h47 through 8'h59, both ends included. Codes outside that band pass the channel stage whatever the selector and tag are.
- R10: A configuration write takes effect from the next clock. An event sampled on the same edge as a write is judged with the settings that were in place before that write.
- R11: Write layout. `cfg_addr` 0 selects the source filter and 1 selects the target filter. In each, bits [10:0] hold the compare value, bits [26:16] hold the mask and bit 31 is the enable. `cfg_addr` 2 takes the channel selector from bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| ev_valid | input | 1 | Event strobe |
| ev_src | input | 11 | Source cluster ID of the event |
| ev_tgt | input | 11 | Target cluster ID of the event |
| ev_ch | input | 2 | Channel tag: bit 0 extended channel, bit 1 normal channel |
| ev_code | input | 8 | Event code |
| qual_pulse | output | 1 | Registered qualified-event pulse |

## Verification
The ID filters are tried with exact matches and with single-bit mismatches, which shows that every unmasked bit is really compared. They are also run with the cluster field masked off against a changed die field, which shows that the mask ignores only the bits it covers. A fully masked filter and a disabled filter holding a mismatched compare value separate masking from enabling. The channel stage is driven at both ends of the code band and just outside them, with each selector value against each channel tag, which separates the two selectors that mean the same thing from the normal-channel selector and from the out-of-band bypass. A write landing on the same edge as an event shows whether old or new settings were applied.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int ID_W     = 11;
  localparam int CODE_W   = 8;
  localparam int CH_W     = 2;
  localparam int CFG_W    = 32;
  localparam int ADDR_W   = 2;
  localparam int MASK_LSB = 16;
  localparam int EN_BIT   = 31;
  localparam logic [CODE_W-1:0] CH_CODE_LO = 8'h47;
  localparam logic [CODE_W-1:0] CH_CODE_HI = 8'h59;

  localparam logic [ADDR_W-1:0] A_SRC = 2'd0;
  localparam logic [ADDR_W-1:0] A_TGT = 2'd1;
  localparam logic [ADDR_W-1:0] A_CH  = 2'd2;

  typedef struct packed {
    logic            en;
    logic [ID_W-1:0] cmd;
    logic [ID_W-1:0] msk;
  } idf_t;

  typedef enum logic [CH_W-1:0] {
    SEL_BOTH  = 2'b00,
    SEL_EXT   = 2'b01,
    SEL_NORM  = 2'b10,
    SEL_EXT_B = 2'b11
  } chsel_e;
endpackage

// File: rtl/evq_cfg_regs.sv
module evq_cfg_regs
  import evq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  wdata,
  output idf_t              src_f,
  output idf_t              tgt_f,
  output chsel_e            sel
);
  function automatic idf_t unpack_idf(input logic [CFG_W-1:0] w);
    idf_t f;
    f.en  = w[EN_BIT];
    f.cmd = w[ID_W-1:0];
    f.msk = w[MASK_LSB +: ID_W];
    return f;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      src_f <= '0;
      tgt_f <= '0;
      sel   <= SEL_BOTH;
    end else if (we) begin
      case (addr)
        A_SRC:   src_f <= unpack_idf(wdata);
        A_TGT:   tgt_f <= unpack_idf(wdata);
        A_CH:    sel   <= chsel_e'(wdata[CH_W-1:0]);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/evq_id_match.sv
module evq_id_match #(
  parameter int W = 11
) (
  input  logic         en,
  input  logic [W-1:0] id,
  input  logic [W-1:0] cmd,
  input  logic [W-1:0] msk,
  output logic         hit
);
  logic [W-1:0] diff;
  always_comb begin
    diff = (id ^ cmd) & ~msk;
    hit  = !en || (diff == '0);
  end
endmodule

// File: rtl/evq_chan_match.sv
module evq_chan_match
  import evq_pkg::*;
(
  input  chsel_e            sel,
  input  logic [CODE_W-1:0] code,
  input  logic [CH_W-1:0]   ch,
  output logic              pass
);
  logic in_band;
  always_comb begin
    in_band = (code >= CH_CODE_LO) && (code <= CH_CODE_HI);
    if (!in_band) begin
      pass = 1'b1;
    end else begin
      case (sel)
        SEL_BOTH:            pass = 1'b1;
        SEL_EXT, SEL_EXT_B:  pass = ch[0];
        SEL_NORM:            pass = ch[1];
        default:             pass = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/event_qualifier.sv
module event_qualifier
  import evq_pkg::*;
#(
  parameter int N_IDF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              ev_valid,
  input  logic [ID_W-1:0]   ev_src,
  input  logic [ID_W-1:0]   ev_tgt,
  input  logic [CH_W-1:0]   ev_ch,
  input  logic [CODE_W-1:0] ev_code,
  output logic              qual_pulse
);
  idf_t   src_f, tgt_f;
  chsel_e sel;

  evq_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .src_f(src_f), .tgt_f(tgt_f), .sel(sel)
  );

  idf_t            filt [N_IDF];
  logic [ID_W-1:0] ids  [N_IDF];
  logic [N_IDF-1:0] hits;

  assign filt[0] = src_f;
  assign filt[1] = tgt_f;
  assign ids[0]  = ev_src;
  assign ids[1]  = ev_tgt;

  for (genvar i = 0; i < N_IDF; i++) begin : g_idf
    evq_id_match #(.W(ID_W)) u_m (
      .en(filt[i].en), .id(ids[i]), .cmd(filt[i].cmd), .msk(filt[i].msk),
      .hit(hits[i])
    );
  end

  logic ch_pass;
  evq_chan_match u_ch (.sel(sel), .code(ev_code), .ch(ev_ch), .pass(ch_pass));

  always_ff @(posedge clk) begin
    if (rst) qual_pulse <= 1'b0;
    else     qual_pulse <= ev_valid && (&hits) && ch_pass;
  end
endmodule

// File: rtl/evq_chk.sv
module evq_chk
  import evq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              ev_valid,
  input logic [ID_W-1:0]   ev_src,
  input logic [ID_W-1:0]   ev_tgt,
  input logic [CH_W-1:0]   ev_ch,
  input logic [CODE_W-1:0] ev_code,
  input logic              qual_pulse,
  input idf_t              src_f,
  input idf_t              tgt_f,
  input chsel_e            sel
);
  logic band_now;
  assign band_now = (ev_code >= CH_CODE_LO) && (ev_code <= CH_CODE_HI);

  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> !qual_pulse); // R1
  AST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    qual_pulse |-> $past(ev_valid)); // R2
  AST_SRC_MATCH: assert property (@(posedge clk) disable iff (rst)
    qual_pulse |-> (!$past(src_f.en) ||
      ((($past(ev_src) ^ $past(src_f.cmd)) & ~$past(src_f.msk)) == '0))); // R3
  AST_TGT_MATCH: assert property (@(posedge clk) disable iff (rst)
    qual_pulse |-> (!$past(tgt_f.en) ||
      ((($past(ev_tgt) ^ $past(tgt_f.cmd)) & ~$past(tgt_f.msk)) == '0))); // R4
  AST_EXT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (qual_pulse && $past(band_now) && $past(sel[0])) |-> $past(ev_ch[0])); // R7
  AST_NORM_ONLY: assert property (@(posedge clk) disable iff (rst)
    (qual_pulse && $past(band_now) && ($past(sel) == SEL_NORM)) |-> $past(ev_ch[1])); // R8
endmodule

bind event_qualifier evq_chk u_chk (
  .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_src(ev_src), .ev_tgt(ev_tgt),
  .ev_ch(ev_ch), .ev_code(ev_code), .qual_pulse(qual_pulse),
  .src_f(src_f), .tgt_f(tgt_f), .sel(sel)
);

// File: tb/tb_event_qualifier.sv
module tb_event_qualifier;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        ev_valid = 1'b0;
  logic [10:0] ev_src = '0, ev_tgt = '0;
  logic [1:0]  ev_ch = '0;
  logic [7:0]  ev_code = '0;
  logic        qual_pulse;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  event_qualifier dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ev_valid(ev_valid), .ev_src(ev_src),
    .ev_tgt(ev_tgt), .ev_ch(ev_ch), .ev_code(ev_code), .qual_pulse(qual_pulse)
  );

  typedef struct packed {
    logic        sen;
    logic [10:0] scmd, smsk;
    logic        ten;
    logic [10:0] tcmd, tmsk;
    logic [1:0]  sel;
    logic [10:0] src, tgt;
    logic [1:0]  ch;
    logic [7:0]  code;
    logic        exp;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b0,11'h000,11'h000, 1'b0,11'h000,11'h000, 2'b00, 11'h2A5,11'h155, 2'b01, 8'h10, 1'b1}, // R5 R6
    '{1'b1,11'h061,11'h000, 1'b0,11'h000,11'h000, 2'b00, 11'h061,11'h000, 2'b00, 8'h10, 1'b1}, // R3 exact
    '{1'b1,11'h061,11'h000, 1'b0,11'h000,11'h000, 2'b00, 11'h063,11'h000, 2'b00, 8'h10, 1'b0}, // R3 one bit off
    '{1'b1,11'h061,11'h01F, 1'b0,11'h000,11'h000, 2'b00, 11'h07F,11'h000, 2'b00, 8'h10, 1'b1}, // R3 cluster masked
    '{1'b1,11'h061,11'h01F, 1'b0,11'h000,11'h000, 2'b00, 11'h09F,11'h000, 2'b00, 8'h10, 1'b0}, // R3 die differs
    '{1'b0,11'h000,11'h000, 1'b1,11'h410,11'h000, 2'b00, 11'h000,11'h410, 2'b00, 8'h10, 1'b1}, // R4 exact
    '{1'b0,11'h000,11'h000, 1'b1,11'h410,11'h000, 2'b00, 11'h000,11'h411, 2'b00, 8'h10, 1'b0}, // R4 mismatch
    '{1'b0,11'h000,11'h000, 1'b1,11'h410,11'h7FF, 2'b00, 11'h000,11'h2AB, 2'b00, 8'h10, 1'b1}, // R4 all masked
    '{1'b0,11'h000,11'h000, 1'b0,11'h000,11'h000, 2'b01, 11'h000,11'h000, 2'b01, 8'h47, 1'b1}, // R7
    '{1'b0,11'h000,11'h000, 1'b0,11'h000,11'h000, 2'b01, 11'h000,11'h000, 2'b10, 8'h47, 1'b0}, // R7
    '{1'b0,11'h000,11'h000, 1'b0,11'h000,11'h000, 2'b11, 11'h000,11'h000, 2'b10, 8'h59, 1'b0}, // R7 alias
    '{1'b0,11'h000,11'h000, 1'b0,11'h000,11'h000, 2'b11, 11'h000,11'h000, 2'b01, 8'h59, 1'b1}, // R7 alias
    '{1'b0,11'h000,11'h000, 1'b0,11'h000,11'h000, 2'b10, 11'h000,11'h000, 2'b10, 8'h50, 1'b1}, // R8
    '{1'b0,11'h000,11'h000, 1'b0,11'h000,11'h000, 2'b10, 11'h000,11'h000, 2'b01, 8'h50, 1'b0}, // R8
    '{1'b0,11'h000,11'h000, 1'b0,11'h000,11'h000, 2'b10, 11'h000,11'h000, 2'b01, 8'h46, 1'b1}, // R9 below band
    '{1'b0,11'h000,11'h000, 1'b0,11'h000,11'h000, 2'b01, 11'h000,11'h000, 2'b10, 8'h5A, 1'b1}, // R9 above band
    '{1'b0,11'h000,11'h000, 1'b0,11'h000,11'h000, 2'b00, 11'h000,11'h000, 2'b01, 8'h50, 1'b1}, // R6 ext
    '{1'b0,11'h000,11'h000, 1'b0,11'h000,11'h000, 2'b00, 11'h000,11'h000, 2'b10, 8'h50, 1'b1}, // R6 normal
    '{1'b0,11'h123,11'h000, 1'b0,11'h000,11'h000, 2'b00, 11'h456,11'h000, 2'b00, 8'h10, 1'b1}, // R5 disabled mismatch
    '{1'b1,11'h061,11'h000, 1'b1,11'h410,11'h000, 2'b00, 11'h061,11'h401, 2'b00, 8'h10, 1'b0}  // R3 R4 both on
  };

  function automatic logic [31:0] idw(input logic en, input logic [10:0] cmd, input logic [10:0] msk);
    return {en, 4'b0, msk, 5'b0, cmd};  // R11 layout
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: qual_pulse=%b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fire(input logic [10:0] s, input logic [10:0] t,
                      input logic [1:0] c, input logic [7:0] code);
    @(negedge clk);
    ev_valid = 1'b1; ev_src = s; ev_tgt = t; ev_ch = c; ev_code = code;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset output", qual_pulse, 1'b0);
    rst = 1'b0;
    // R1: defaults count everything, even in-band code on normal channel
    fire(11'h7FF, 11'h3C3, 2'b10, 8'h48);
    check("R1 defaults pass", qual_pulse, 1'b1);
    // R2: pulse lasts one cycle, nothing without valid
    @(negedge clk);
    check("R2 no valid no pulse", qual_pulse, 1'b0);

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, idw(VEC[i].sen, VEC[i].scmd, VEC[i].smsk));
      wr(2'd1, idw(VEC[i].ten, VEC[i].tcmd, VEC[i].tmsk));
      wr(2'd2, {30'b0, VEC[i].sel});
      fire(VEC[i].src, VEC[i].tgt, VEC[i].ch, VEC[i].code);
      check($sformatf("R3-R9 R11 vector %0d", i), qual_pulse, VEC[i].exp);
    end

    // R10: write and event on the same edge -> old settings apply
    wr(2'd2, 32'd0);
    wr(2'd1, 32'd0);
    wr(2'd0, idw(1'b1, 11'h001, 11'h000));
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = idw(1'b1, 11'h002, 11'h000);
    ev_valid = 1'b1; ev_src = 11'h002; ev_tgt = '0; ev_ch = '0; ev_code = 8'h10;
    @(negedge clk);
    cfg_we = 1'b0; ev_valid = 1'b0;
    check("R10 same-cycle uses old cmd", qual_pulse, 1'b0);
    fire(11'h002, 11'h000, 2'b00, 8'h10);
    check("R10 new cmd next clock", qual_pulse, 1'b1);
    // R10: same-cycle disable does not yet release the filter
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'd0;
    ev_valid = 1'b1; ev_src = 11'h005;
    @(negedge clk);
    cfg_we = 1'b0; ev_valid = 1'b0;
    check("R10 same-cycle disable ignored", qual_pulse, 1'b0);
    fire(11'h005, 11'h000, 2'b00, 8'h10);
    check("R5 R10 disabled after write", qual_pulse, 1'b1);

    // R11: address 3 writes nothing; channel selector 2'b10 stays in force
    wr(2'd2, 32'd2);
    wr(2'd3, 32'hFFFF_FFFF);
    fire(11'h000, 11'h000, 2'b01, 8'h50);
    check("R11 unused address", qual_pulse, 1'b0);

    // R1: reset restores defaults
    wr(2'd0, idw(1'b1, 11'h001, 11'h000));
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    fire(11'h3FF, 11'h000, 2'b01, 8'h50);
    check("R1 reset clears filters", qual_pulse, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule